// File: doc/BRIEF.md
# Alternate Bus Master Acquisition Controller

This block sits inside a device that occasionally needs to become master of a processor bus, such as a DMA engine. When its local transfer queue holds work, it raises a bus request and waits for the processor to grant the bus. A grant only promises that the bus will be handed over once the current cycle ends. So the controller then waits until the bus is actually quiet before it enables its own drivers. The bus is quiet when the address strobe is inactive, both transfer-acknowledge bits are inactive and no rival external master has claimed the bus.

During its tenure the controller keeps the request high. The request doubles as the signal that holds ownership across any number of transfers. The controller also raises an own-bus enable for the local transfer logic and a claim line that other masters watch. When the queue drains, it drops all three outputs together. It then holds the request low for a programmable gap before it may ask again. Grant, strobe and acknowledge are asynchronous to the local clock and pass through a synchronizer first. The rival-claim input comes from local-clock logic and is used directly. The transfer datapath itself lies outside this block.

All ports are active high. A 1 on `strobe_i` means the strobe is asserted. A 1 on any bit of `ack_i` means that acknowledge bit is asserted.

Top module: `altmst_bus_acq`

## Requirements
- R1: While reset is applied, and after it is released with an empty queue, `bus_req_o`, `own_en_o` and `claim_o` are all 0.
- R2: When `xfer_pending_i` is 1 while the controller is idle, `bus_req_o` becomes 1 one cycle later.
- R3: While the request is up and any busy condition holds, `own_en_o` and `claim_o` stay 0 and `bus_req_o` stays 1. The busy conditions are: `strobe_i` = 1, any bit of `ack_i` = 1, or `rival_claim_i` = 1.
- R4: If the bus is already quiet, `own_en_o` rises SYNC_STAGES+2 cycles after `grant_i` rises, which is 4 cycles at the default setting.
- R5: With grant held, `own_en_o` rises SYNC_STAGES+1 cycles after the last of strobe or acknowledge goes inactive. It rises 1 cycle after `rival_claim_i` falls when that is the last busy condition.
- R6: `claim_o` equals `own_en_o` in every cycle, and `bus_req_o` is 1 whenever `own_en_o` is 1.
- R7: If the grant is withdrawn before ownership is taken, the controller does not take the bus when it later becomes quiet. It needs a fresh synchronized grant first.
- R8: While owning the bus with `xfer_pending_i` = 1, `bus_req_o` and `own_en_o` stay 1 whatever `strobe_i` and `ack_i` do.
- R9: When `xfer_pending_i` is 0 while owning, `bus_req_o`, `own_en_o` and `claim_o` all fall one cycle later.
- R10: After a release, `bus_req_o` stays 0 for at least REL_HOLD+1 cycles. With the queue refilled one cycle after it emptied, the request returns REL_HOLD+1 cycles after the refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xfer_pending_i | input | 1 | Local transfer queue holds work |
| grant_i | input | 1 | Bus grant from the processor (asynchronous) |
| strobe_i | input | 1 | Bus address strobe asserted (asynchronous) |
| ack_i | input | ACK_W | Transfer acknowledge bits, 1 = asserted (asynchronous) |
| rival_claim_i | input | 1 | Another external master has claimed the bus |
| bus_req_o | output | 1 | Bus request, held for the whole tenure |
| own_en_o | output | 1 | Enable for this device's bus drivers and transfers |
| claim_o | output | 1 | Ownership claim seen by other masters |

## Verification
Each result has a fixed latency from the stimulus that causes it. A queue change reaches the request or release outputs after one clock. A rival-claim change reaches the enable after one clock. A change on grant, strobe or acknowledge crosses the SYNC_STAGES synchronizer and the state register before it shows, so it lands SYNC_STAGES+1 cycles later, plus one more when the grant must first move the controller into its wait state. The bench stamps each expected value with the exact cycle count at which it falls due. It then compares on the falling edge of that cycle, and it also places a check just before the due cycle to show that the change did not come early.

// File: rtl/altmst_pkg.sv
package altmst_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT_FREE,
    ST_OWN,
    ST_RELEASE
  } acq_state_e;
endpackage

// File: rtl/acq_rst_sync.sv
module acq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/acq_sync.sv
module acq_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[k] <= '0;
        else        stage_q[k] <= stage_q[k-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import altmst_pkg::*;
#(
  parameter int ACK_W    = 2,
  parameter int REL_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pending_i,
  input  logic             grant_i,
  input  logic             strobe_i,
  input  logic [ACK_W-1:0] ack_i,
  input  logic             rival_i,
  output logic             req_o,
  output logic             own_o,
  output logic             claim_o
);
  localparam int REL_CNT_W = (REL_HOLD > 1) ? $clog2(REL_HOLD) : 1;
  localparam logic [REL_CNT_W-1:0] REL_LAST = REL_CNT_W'(REL_HOLD - 1);

  acq_state_e           state_q, state_d;
  logic [REL_CNT_W-1:0] rel_cnt_q, rel_cnt_d;
  logic                 rel_cnt_en;
  logic                 rel_done;
  logic                 bus_quiet;

  assign bus_quiet = !strobe_i && (ack_i == '0) && !rival_i;
  assign rel_done  = (rel_cnt_q == REL_LAST);

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:      if (pending_i) state_d = ST_REQ;
      ST_REQ:       if (grant_i)   state_d = ST_WAIT_FREE;
      ST_WAIT_FREE: begin
        if (!grant_i)       state_d = ST_REQ;
        else if (bus_quiet) state_d = ST_OWN;
      end
      ST_OWN:       if (!pending_i) state_d = ST_RELEASE;
      ST_RELEASE:   if (rel_done)   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // release gap counter: counts only while releasing, clears afterwards
  assign rel_cnt_en = (state_q == ST_RELEASE) || (rel_cnt_q != '0);
  assign rel_cnt_d  = ((state_q == ST_RELEASE) && !rel_done) ? rel_cnt_q + 1'b1 : '0;

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rel_cnt_q <= '0;
    else if (rel_cnt_en) rel_cnt_q <= rel_cnt_d;
  end

  assign req_o   = (state_q == ST_REQ) || (state_q == ST_WAIT_FREE) || (state_q == ST_OWN);
  assign own_o   = (state_q == ST_OWN);
  assign claim_o = own_o;

  assert_idle_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && pending_i) |=> req_o);

  assert_take_when_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own_o) |-> $past(grant_i && !strobe_i && (ack_i == '0) && !rival_i));

  assert_own_holds_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    own_o |-> req_o);

  assert_grant_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT_FREE && !grant_i) |=> !own_o);

  assert_tenure_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_o && pending_i) |=> (own_o && req_o));

  assert_release_together_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (own_o && !pending_i) |=> (!req_o && !own_o && !claim_o));

  assert_request_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |=> !req_o);
endmodule

// File: rtl/altmst_bus_acq.sv
module altmst_bus_acq #(
  parameter int ACK_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  parameter int REL_HOLD    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_pending_i,
  input  logic             grant_i,
  input  logic             strobe_i,
  input  logic [ACK_W-1:0] ack_i,
  input  logic             rival_claim_i,
  output logic             bus_req_o,
  output logic             own_en_o,
  output logic             claim_o
);
  localparam int SYNC_W = ACK_W + 2;

  logic              rst_n_int;
  logic [SYNC_W-1:0] async_vec;
  logic [SYNC_W-1:0] sync_vec;

  acq_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  assign async_vec = {grant_i, strobe_i, ack_i};

  acq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_i   (async_vec),
    .q_o   (sync_vec)
  );

  acq_fsm #(.ACK_W(ACK_W), .REL_HOLD(REL_HOLD)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .pending_i (xfer_pending_i),
    .grant_i   (sync_vec[SYNC_W-1]),
    .strobe_i  (sync_vec[SYNC_W-2]),
    .ack_i     (sync_vec[ACK_W-1:0]),
    .rival_i   (rival_claim_i),
    .req_o     (bus_req_o),
    .own_o     (own_en_o),
    .claim_o   (claim_o)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n_int |-> (!bus_req_o && !own_en_o && !claim_o));
endmodule

// File: tb/sim_altmst_bus_acq.sv
`timescale 1ns/1ps
module sim_altmst_bus_acq;
  localparam int SYNC = 2;
  localparam int REL  = 2;
  localparam int AW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pend = 1'b0, grant = 1'b0, strobe = 1'b1, rival = 1'b0;
  logic [AW-1:0] ack = '0;
  logic          req, own, claim;

  altmst_bus_acq #(.ACK_W(AW), .SYNC_STAGES(SYNC), .RST_STAGES(2), .REL_HOLD(REL)) u0 (
    .clk(clk), .rst_n(rst_n), .xfer_pending_i(pend), .grant_i(grant),
    .strobe_i(strobe), .ack_i(ack), .rival_claim_i(rival),
    .bus_req_o(req), .own_en_o(own), .claim_o(claim)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    logic  req;
    logic  own;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   compared = 0;
  int   mismatched = 0;
  bit   done = 1'b0;

  // driver side: push an expectation due k clock edges from now
  task automatic expect_in(input int k, input logic r, input logic o, input string tag);
    exp_t e;
    e.due = cyc + k;
    e.req = r;
    e.own = o;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every item due this cycle; claim must follow own (R6)
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        compared++;
        if (req !== sb[i].req || own !== sb[i].own || claim !== sb[i].own) begin
          mismatched++;
          $display("FAIL %s (R6 claim) cycle %0d: req/own/claim=%b%b%b expected %b%b%b",
                   sb[i].tag, cyc, req, own, claim, sb[i].req, sb[i].own, sb[i].own);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual pending=%0d expected 0", sb.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tick(1);
    rst_n = 1'b1;
    tick(6);
    // R1: quiet after reset with an empty queue
    expect_in(1, 1'b0, 1'b0, "R1");
    expect_in(3, 1'b0, 1'b0, "R1");
    tick(3);

    // R2: request one cycle after the queue fills
    pend = 1'b1;
    expect_in(1, 1'b1, 1'b0, "R2");
    tick(2);

    // R3: grant while strobe busy
    grant = 1'b1;
    expect_in(SYNC + 2, 1'b1, 1'b0, "R3");
    expect_in(SYNC + 5, 1'b1, 1'b0, "R3");
    tick(SYNC + 5);
    // R5: strobe goes quiet
    strobe = 1'b0;
    expect_in(SYNC,     1'b1, 1'b0, "R5");
    expect_in(SYNC + 1, 1'b1, 1'b1, "R5");
    tick(SYNC + 2);

    // R8: bus activity during tenure is ignored
    strobe = 1'b1;
    ack = '1;
    expect_in(SYNC + 2, 1'b1, 1'b1, "R8");
    expect_in(SYNC + 4, 1'b1, 1'b1, "R8");
    tick(SYNC + 4);
    strobe = 1'b0;
    ack = '0;
    tick(SYNC + 1);

    // R9 / R10: release and refill
    pend = 1'b0;
    grant = 1'b0;
    expect_in(1, 1'b0, 1'b0, "R9");
    tick(1);
    pend = 1'b1;
    expect_in(REL,     1'b0, 1'b0, "R10");
    expect_in(REL + 1, 1'b1, 1'b0, "R10");
    tick(REL + 2);

    // R3 / R5: each acknowledge bit blocks on its own
    ack = 2'b01;
    grant = 1'b1;
    expect_in(SYNC + 4, 1'b1, 1'b0, "R3");
    tick(SYNC + 4);
    ack = 2'b10;
    expect_in(SYNC + 2, 1'b1, 1'b0, "R3");
    tick(SYNC + 2);
    ack = 2'b00;
    expect_in(SYNC,     1'b1, 1'b0, "R5");
    expect_in(SYNC + 1, 1'b1, 1'b1, "R5");
    tick(SYNC + 2);
    pend = 1'b0;
    grant = 1'b0;
    expect_in(1, 1'b0, 1'b0, "R9");
    tick(REL + 4);

    // R3 / R5: rival master claim blocks, clears in one cycle
    pend = 1'b1;
    rival = 1'b1;
    grant = 1'b1;
    expect_in(SYNC + 4, 1'b1, 1'b0, "R3");
    tick(SYNC + 4);
    rival = 1'b0;
    expect_in(1, 1'b1, 1'b1, "R5");
    tick(2);
    pend = 1'b0;
    grant = 1'b0;
    tick(REL + 4);

    // R7: grant withdrawn while waiting for a quiet bus
    pend = 1'b1;
    strobe = 1'b1;
    grant = 1'b1;
    tick(SYNC + 4);
    grant = 1'b0;
    tick(SYNC + 2);
    strobe = 1'b0;
    expect_in(SYNC + 1, 1'b1, 1'b0, "R7");
    expect_in(SYNC + 4, 1'b1, 1'b0, "R7");
    tick(SYNC + 4);
    // R4: fresh grant on an already quiet bus
    grant = 1'b1;
    expect_in(SYNC + 1, 1'b1, 1'b0, "R4");
    expect_in(SYNC + 2, 1'b1, 1'b1, "R4");
    tick(SYNC + 3);
    pend = 1'b0;
    grant = 1'b0;
    expect_in(1, 1'b0, 1'b0, "R9");
    tick(REL + 3);

    while (sb.size() != 0) tick(1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule